// File: doc/BRIEF.md
# Crypto Command Queue Decoder

This block sits between a register front end and a cipher engine. Software pushes 32-bit words one at a time into a nine-word queue. The first word of each command holds an opcode and packed fields, and the words after it are payload. The block keeps collecting words until the command at the head of the queue has all of its payload. It then carries out that command in place and empties the queue.

The commands are:
- loading a key into one of two key contexts, either from payload words or by picking a built-in key;
- loading one of four 128-bit IV slots;
- handing a data-transfer descriptor to a DMA engine over a valid/ready pair;
- issuing a one-cycle request to write an IV slot out to memory;
- latching an 8-bit flag value, optionally with an interrupt cause.

A word written while the queue is full is dropped. A command whose opcode is not supported raises an invalid-command cause and stays at the head of the queue.

Timing and the descriptor stall:
- Evaluation is registered. A word stored at one rising edge is evaluated in the following cycle, so its effects show after the next edge.
- While a descriptor is waiting for its consumer, the queue keeps accepting words but executes nothing.

Top module: `crypto_cmd_decoder`

## Requirements
- R1: The queue holds up to 9 words. A word written while 9 words are held and no command is executing is dropped and never reaches any command.
- R2: The opcode is bits 31:28 of the head word: 1 key, 2 IV, 5 data, 6 store IV, 8 flag. Any other opcode gives a one-cycle `badCmdIrq` pulse on each evaluation and is not removed, so every later write pulses it again.
- R3: A command executes in the cycle after the word that completes it is stored. Its register results and pulses are visible after the following rising edge. A command that is still missing payload changes nothing.
- R4: In a key command, bit 27 selects the context, bits 23:22 give the length code (0, 1, 2 = 4, 6, 8 payload words), bit 20 sets encrypt and bits 17:16 set the mode (0 ECB, 1 CBC). Payload word i goes to key bits 32(i-1)+31:32(i-1). Context c appears at `keyData[256c+255:256c]` and its length code at `keyLenCode[2c+1:2c]`.
- R5: A key command with a nonzero selector in bits 26:24 executes with no payload. It sets the context's key to the zero-extended selector value and its length code to 2, and it also updates mode and encrypt.
- R6: A key command with mode 2 or 3 never executes. A non-built-in key command with length code 3 never executes.
- R7: An IV command needs 4 payload words and loads slot bits 27:26 as {w4,w3,w2,w1}. Slot s appears at `ivData[128s+127:128s]`.
- R8: A data command needs 3 payload words. It produces a descriptor with:
  - length taken from bits 23:0;
  - key context from bit 27 and IV slot from bits 26:25;
  - source address {w1[31:16], w2} and destination address {w1[15:0], w3};
  - the current mode and encrypt settings.
- R9: `descValid` and the descriptor fields hold until a cycle with `descReady` high. Until then no command executes, although words are still queued.
- R10: A store-IV command needs 1 payload word. It gives a one-cycle `ivStoreValid` with address {cmd[7:0], w1} and the data of IV slot bits 27:26.
- R11: A flag command latches bits 7:0 into `flagInfo`. It pulses `flagIrq` for one cycle only when bit 27 is set.
- R12: After reset, all key, IV, descriptor, flag and pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Queue write strobe |
| wrData | input | 32 | Command or payload word |
| keyData | output | 512 | Key contexts, 256 bits each |
| keyLenCode | output | 4 | Key length codes, 2 bits per context |
| ivData | output | 512 | IV slots, 128 bits each |
| cbcMode | output | 1 | Current block mode, 1 = CBC |
| encryptMode | output | 1 | Current direction, 1 = encrypt |
| descValid | output | 1 | Descriptor valid |
| descReady | input | 1 | Descriptor accepted by consumer |
| descSrc | output | 48 | Source address |
| descDst | output | 48 | Destination address |
| descLen | output | 24 | Byte length |
| descCbc | output | 1 | Mode for the transfer |
| descEncrypt | output | 1 | Direction for the transfer |
| descKeyCtx | output | 1 | Key context for the transfer |
| descIvSlot | output | 2 | IV slot for the transfer |
| ivStoreValid | output | 1 | One-cycle IV store request |
| ivStoreAddr | output | 40 | IV store address |
| ivStoreData | output | 128 | IV value to store |
| flagInfo | output | 8 | Last flag value |
| flagIrq | output | 1 | Flag cause pulse |
| badCmdIrq | output | 1 | Invalid-command cause pulse |

## Verification
A wrong queue count or a wrong payload threshold shows as a key, IV or descriptor field that changes one write too early or not at all, one cycle after the deciding word. A lost evaluation flag shows as a command that never executes. A stall that leaks shows as a flag or store pulse, or a descriptor change, while `descValid` is high and `descReady` is low. Saturation of a full queue is visible only after a stall is released, when the executed key must hold exactly the first eight payload words.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam logic [3:0] OP_KEY   = 4'h1;
  localparam logic [3:0] OP_IV    = 4'h2;
  localparam logic [3:0] OP_DATA  = 4'h5;
  localparam logic [3:0] OP_STIV  = 4'h6;
  localparam logic [3:0] OP_FLAG  = 4'h8;

  localparam int KEY_CTX   = 2;
  localparam int IV_SLOTS  = 4;
  localparam int KEY_BITS  = 256;
  localparam int IV_BITS   = 128;
  localparam int KEY_WORDS = KEY_BITS / 32;

  typedef struct packed {
    logic clearQ;
    logic keyNew;
    logic keyBuiltin;
    logic ivLoad;
    logic descLoad;
    logic ivStore;
    logic flagLatch;
    logic flagIrq;
    logic badCmd;
  } ccd_strobe_t;
endpackage

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
  import ccd_pkg::*;
#(
  parameter int QDEPTH = 9,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic             evalEn,
  input  logic [3:0]       opcode,
  input  logic             bit27,
  input  logic [2:0]       keySel,
  input  logic [1:0]       lenCode,
  input  logic [1:0]       modeField,
  input  logic [CNT_W-1:0] count,
  output ccd_strobe_t      stb,
  output logic [3:0]       keyWords
);
  logic [CNT_W-1:0] keyNeed;

  always_comb begin
    keyWords = 4'd4 + {1'b0, lenCode, 1'b0};
    keyNeed  = CNT_W'(keyWords) + CNT_W'(1);
    stb      = '0;
    if (evalEn) begin
      unique case (opcode)
        OP_KEY: begin
          if (!modeField[1]) begin
            if (keySel != 3'd0) begin
              stb.keyBuiltin = 1'b1;
              stb.clearQ     = 1'b1;
            end else if (lenCode != 2'd3 && count >= keyNeed) begin
              stb.keyNew = 1'b1;
              stb.clearQ = 1'b1;
            end
          end
        end
        OP_IV: if (count >= CNT_W'(5)) begin
          stb.ivLoad = 1'b1;
          stb.clearQ = 1'b1;
        end
        OP_DATA: if (count >= CNT_W'(4)) begin
          stb.descLoad = 1'b1;
          stb.clearQ   = 1'b1;
        end
        OP_STIV: if (count >= CNT_W'(2)) begin
          stb.ivStore = 1'b1;
          stb.clearQ  = 1'b1;
        end
        OP_FLAG: begin
          stb.flagLatch = 1'b1;
          stb.flagIrq   = bit27;
          stb.clearQ    = 1'b1;
        end
        default: stb.badCmd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ccd_dpath.sv
module ccd_dpath
  import ccd_pkg::*;
#(
  parameter int QDEPTH = 9,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wrValid,
  input  logic [31:0]                  wrData,
  input  ccd_strobe_t                  stb,
  input  logic [3:0]                   keyWords,
  input  logic                         descReady,
  output logic                         evalEn,
  output logic [31:0]                  head,
  output logic [CNT_W-1:0]             count,
  output logic [KEY_CTX*KEY_BITS-1:0]  keyFlat,
  output logic [KEY_CTX*2-1:0]         lenFlat,
  output logic [IV_SLOTS*IV_BITS-1:0]  ivFlat,
  output logic                         cbcMode,
  output logic                         encryptMode,
  output logic                         descValid,
  output logic [47:0]                  descSrc,
  output logic [47:0]                  descDst,
  output logic [23:0]                  descLen,
  output logic                         descCbc,
  output logic                         descEncrypt,
  output logic                         descKeyCtx,
  output logic [1:0]                   descIvSlot,
  output logic                         ivStoreValid,
  output logic [39:0]                  ivStoreAddr,
  output logic [IV_BITS-1:0]           ivStoreData,
  output logic [7:0]                   flagInfo,
  output logic                         flagIrq,
  output logic                         badCmdIrq
);
  logic [31:0]         q [QDEPTH];
  logic                evalPend;
  logic                accept;
  logic [CNT_W-1:0]    wIdx;
  logic [KEY_BITS-1:0] keyData [KEY_CTX];
  logic [1:0]          keyLen  [KEY_CTX];
  logic [IV_BITS-1:0]  ivData  [IV_SLOTS];

  assign head   = q[0];
  assign evalEn = evalPend && !descValid;
  assign accept = wrValid && (stb.clearQ || count < CNT_W'(QDEPTH));
  assign wIdx   = stb.clearQ ? '0 : count;

  for (genvar c = 0; c < KEY_CTX; c++) begin : g_key
    assign keyFlat[c*KEY_BITS +: KEY_BITS] = keyData[c];
    assign lenFlat[c*2 +: 2] = keyLen[c];
  end
  for (genvar s = 0; s < IV_SLOTS; s++) begin : g_iv
    assign ivFlat[s*IV_BITS +: IV_BITS] = ivData[s];
  end

  // queue storage and evaluation trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
      count    <= '0;
      evalPend <= 1'b0;
    end else begin
      if (accept) q[wIdx] <= wrData;
      if (stb.clearQ) count <= wrValid ? CNT_W'(1) : '0;
      else if (accept) count <= count + CNT_W'(1);
      if (wrValid) evalPend <= 1'b1;
      else if (evalEn) evalPend <= 1'b0;
    end
  end

  // context stores
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < KEY_CTX; c++) begin
        keyData[c] <= '0;
        keyLen[c]  <= '0;
      end
      for (int s = 0; s < IV_SLOTS; s++) ivData[s] <= '0;
      cbcMode     <= 1'b0;
      encryptMode <= 1'b0;
    end else begin
      if (stb.keyNew) begin
        for (int i = 0; i < KEY_WORDS; i++)
          if (i < int'(keyWords)) keyData[head[27]][32*i +: 32] <= q[i+1];
        keyLen[head[27]] <= head[23:22];
      end
      if (stb.keyBuiltin) begin
        keyData[head[27]] <= KEY_BITS'(head[26:24]);
        keyLen[head[27]]  <= 2'd2;
      end
      if (stb.keyNew || stb.keyBuiltin) begin
        cbcMode     <= head[16];
        encryptMode <= head[20];
      end
      if (stb.ivLoad) ivData[head[27:26]] <= {q[4], q[3], q[2], q[1]};
    end
  end

  // descriptor, store request, flag and causes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      descValid    <= 1'b0;
      descSrc      <= '0;
      descDst      <= '0;
      descLen      <= '0;
      descCbc      <= 1'b0;
      descEncrypt  <= 1'b0;
      descKeyCtx   <= 1'b0;
      descIvSlot   <= '0;
      ivStoreValid <= 1'b0;
      ivStoreAddr  <= '0;
      ivStoreData  <= '0;
      flagInfo     <= '0;
      flagIrq      <= 1'b0;
      badCmdIrq    <= 1'b0;
    end else begin
      if (stb.descLoad) begin
        descValid   <= 1'b1;
        descSrc     <= {q[1][31:16], q[2]};
        descDst     <= {q[1][15:0], q[3]};
        descLen     <= head[23:0];
        descCbc     <= cbcMode;
        descEncrypt <= encryptMode;
        descKeyCtx  <= head[27];
        descIvSlot  <= head[26:25];
      end else if (descValid && descReady) begin
        descValid <= 1'b0;
      end
      ivStoreValid <= stb.ivStore;
      if (stb.ivStore) begin
        ivStoreAddr <= {head[7:0], q[1]};
        ivStoreData <= ivData[head[27:26]];
      end
      if (stb.flagLatch) flagInfo <= head[7:0];
      flagIrq   <= stb.flagIrq;
      badCmdIrq <= stb.badCmd;
    end
  end
endmodule

// File: rtl/crypto_cmd_decoder.sv
module crypto_cmd_decoder
  import ccd_pkg::*;
#(
  parameter int QDEPTH = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrValid,
  input  logic [31:0]   wrData,
  output logic [511:0]  keyData,
  output logic [3:0]    keyLenCode,
  output logic [511:0]  ivData,
  output logic          cbcMode,
  output logic          encryptMode,
  output logic          descValid,
  input  logic          descReady,
  output logic [47:0]   descSrc,
  output logic [47:0]   descDst,
  output logic [23:0]   descLen,
  output logic          descCbc,
  output logic          descEncrypt,
  output logic          descKeyCtx,
  output logic [1:0]    descIvSlot,
  output logic          ivStoreValid,
  output logic [39:0]   ivStoreAddr,
  output logic [127:0]  ivStoreData,
  output logic [7:0]    flagInfo,
  output logic          flagIrq,
  output logic          badCmdIrq
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  ccd_strobe_t      stb;
  logic             evalEn;
  logic [31:0]      head;
  logic [CNT_W-1:0] count;
  logic [3:0]       keyWords;

  ccd_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
    .evalEn(evalEn), .opcode(head[31:28]), .bit27(head[27]),
    .keySel(head[26:24]), .lenCode(head[23:22]), .modeField(head[17:16]),
    .count(count), .stb(stb), .keyWords(keyWords)
  );

  ccd_dpath #(.QDEPTH(QDEPTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .stb(stb), .keyWords(keyWords), .descReady(descReady),
    .evalEn(evalEn), .head(head), .count(count),
    .keyFlat(keyData), .lenFlat(keyLenCode), .ivFlat(ivData),
    .cbcMode(cbcMode), .encryptMode(encryptMode),
    .descValid(descValid), .descSrc(descSrc), .descDst(descDst),
    .descLen(descLen), .descCbc(descCbc), .descEncrypt(descEncrypt),
    .descKeyCtx(descKeyCtx), .descIvSlot(descIvSlot),
    .ivStoreValid(ivStoreValid), .ivStoreAddr(ivStoreAddr),
    .ivStoreData(ivStoreData), .flagInfo(flagInfo),
    .flagIrq(flagIrq), .badCmdIrq(badCmdIrq)
  );
endmodule

// File: rtl/ccd_checker.sv
module ccd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        descValid,
  input logic        descReady,
  input logic [47:0] descSrc,
  input logic [23:0] descLen,
  input logic        flagIrq,
  input logic        badCmdIrq,
  input logic        ivStoreValid
);
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && !descReady |=> descValid && $stable(descSrc)); // R9
  AST_DESC_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    descValid && !descReady |=> $stable(descLen)); // R8
  AST_NO_EXEC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |=> !flagIrq && !badCmdIrq && !ivStoreValid); // R9
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flagIrq, badCmdIrq, ivStoreValid})); // R2
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ivStoreValid |=> !ivStoreValid); // R10
endmodule

bind crypto_cmd_decoder ccd_checker u_chk (.*);

// File: tb/crypto_cmd_decoder_bench.sv
module crypto_cmd_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic descReady = 1'b0;
  logic [511:0] keyData, ivData;
  logic [3:0] keyLenCode;
  logic cbcMode, encryptMode, descValid, descCbc, descEncrypt, descKeyCtx;
  logic [47:0] descSrc, descDst;
  logic [23:0] descLen;
  logic [1:0] descIvSlot;
  logic ivStoreValid, flagIrq, badCmdIrq;
  logic [39:0] ivStoreAddr;
  logic [127:0] ivStoreData;
  logic [7:0] flagInfo;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  crypto_cmd_decoder u_crypto_cmd_decoder (.*);

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    wrValid = 1'b0; descReady = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] w);
    wrValid = 1'b1; wrData = w;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 descValid", 512'(descValid), 512'(0));
    chk("R12 keyData", keyData, 512'(0));
    chk("R12 ivData", ivData, 512'(0));
    chk("R12 flagInfo", 512'(flagInfo), 512'(0));
    chk("R12 pulses", 512'({flagIrq, badCmdIrq, ivStoreValid}), 512'(0));
  endtask

  task automatic t_flag();
    wr(32'h8800_005A); step();
    chk("R11 flagInfo", 512'(flagInfo), 512'(8'h5A));
    chk("R11 flagIrq set", 512'(flagIrq), 512'(1));
    step();
    chk("R11 flagIrq one cycle", 512'(flagIrq), 512'(0));
    wr(32'h8000_0033); step();
    chk("R11 flagInfo no irq", 512'(flagInfo), 512'(8'h33));
    chk("R11 no flagIrq", 512'(flagIrq), 512'(0));
  endtask

  task automatic t_invalid();
    wr(32'h3000_0000); step();
    chk("R2 badCmdIrq", 512'(badCmdIrq), 512'(1));
    step();
    chk("R2 pulse drops", 512'(badCmdIrq), 512'(0));
    wr(32'h8800_0077); step();
    chk("R2 head kept badCmdIrq", 512'(badCmdIrq), 512'(1));
    chk("R2 flag not run", 512'(flagIrq), 512'(0));
    chk("R2 flagInfo unchanged", 512'(flagInfo), 512'(8'h33));
    do_reset();
  endtask

  task automatic t_iv_store();
    wr(32'h2800_0000);
    wr(32'hA000_0001); wr(32'hA000_0002); wr(32'hA000_0003); step();
    chk("R3 IV incomplete", ivData[256 +: 128], 512'(0));
    wr(32'hA000_0004); step();
    chk("R7 IV slot2", 512'(ivData[256 +: 128]),
        512'({32'hA000_0004, 32'hA000_0003, 32'hA000_0002, 32'hA000_0001}));
    chk("R7 IV slot0 untouched", 512'(ivData[0 +: 128]), 512'(0));
    wr(32'h6800_00C3); wr(32'h1234_5678);
    chk("R10 not yet", 512'(ivStoreValid), 512'(0));
    step();
    chk("R10 ivStoreValid", 512'(ivStoreValid), 512'(1));
    chk("R10 ivStoreAddr", 512'(ivStoreAddr), 512'(40'hC3_1234_5678));
    chk("R10 ivStoreData", 512'(ivStoreData),
        512'({32'hA000_0004, 32'hA000_0003, 32'hA000_0002, 32'hA000_0001}));
    step();
    chk("R10 one cycle", 512'(ivStoreValid), 512'(0));
  endtask

  task automatic t_key_new();
    wr(32'h1800_0000);
    wr(32'hB000_0000); wr(32'hB000_0001); wr(32'hB000_0002); step();
    chk("R3 key incomplete", 512'(keyData[256 +: 256]), 512'(0));
    wr(32'hB000_0003); step();
    chk("R4 key ctx1 128", 512'(keyData[256 +: 256]),
        512'({32'hB000_0003, 32'hB000_0002, 32'hB000_0001, 32'hB000_0000}));
    chk("R4 len code ctx1", 512'(keyLenCode[3:2]), 512'(0));
    chk("R4 ecb decrypt", 512'({cbcMode, encryptMode}), 512'(0));
  endtask

  task automatic t_key_builtin();
    wr(32'h1301_0000); step();
    chk("R5 builtin key", 512'(keyData[0 +: 256]), 512'(3));
    chk("R5 builtin len", 512'(keyLenCode[1:0]), 512'(2));
    chk("R5 cbc", 512'(cbcMode), 512'(1));
  endtask

  task automatic t_key_fail();
    wr(32'h10C0_0000);
    for (int i = 0; i < 8; i++) wr(32'hC000_0000 + i);
    step();
    chk("R6 len code 3 ignored", 512'(keyData[0 +: 256]), 512'(0));
    do_reset();
    wr(32'h1102_0000); step();
    chk("R6 mode 2 ignored key", 512'(keyData[0 +: 256]), 512'(0));
    chk("R6 mode 2 ignored len", 512'(keyLenCode), 512'(0));
    do_reset();
  endtask

  task automatic t_data_stall();
    wr(32'h1301_0000);
    wr(32'h5400_0100); wr(32'hABCD_1234); wr(32'h1000_0000);
    chk("R8 not yet", 512'(descValid), 512'(0));
    wr(32'h2000_0000); step();
    chk("R8 descValid", 512'(descValid), 512'(1));
    chk("R8 descSrc", 512'(descSrc), 512'(48'hABCD_1000_0000));
    chk("R8 descDst", 512'(descDst), 512'(48'h1234_2000_0000));
    chk("R8 descLen", 512'(descLen), 512'(24'h100));
    chk("R8 ctx fields", 512'({descKeyCtx, descIvSlot, descCbc, descEncrypt}),
        512'(5'b0_10_1_0));
    wr(32'h8800_00AA); step(); step();
    chk("R9 held", 512'(descValid), 512'(1));
    chk("R9 no exec", 512'(flagInfo), 512'(0));
    descReady = 1'b1; step(); descReady = 1'b0;
    chk("R9 released", 512'(descValid), 512'(0));
    step();
    chk("R9 flag after release", 512'({flagIrq, flagInfo}), 512'({1'b1, 8'hAA}));
  endtask

  task automatic t_full_discard();
    logic [255:0] expKey;
    wr(32'h5000_0010); wr(32'h0); wr(32'h0); wr(32'h0); step();
    chk("R8 second desc", 512'(descValid), 512'(1));
    wr(32'h1091_0000);
    for (int i = 0; i < 8; i++) begin
      wr(32'hD000_0000 + i);
      expKey[32*i +: 32] = 32'hD000_0000 + i;
    end
    wr(32'h3FFF_FFFF); step();
    descReady = 1'b1; step(); descReady = 1'b0; step();
    chk("R1 key from first 8 words", 512'(keyData[0 +: 256]), 512'(expKey));
    chk("R1 tenth word dropped", 512'(badCmdIrq), 512'(0));
    chk("R4 cbc encrypt", 512'({cbcMode, encryptMode}), 512'(2'b11));
    chk("R4 len code 2", 512'(keyLenCode[1:0]), 512'(2));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_flag();
    t_invalid();
    t_iv_store();
    t_key_new();
    t_key_builtin();
    do_reset();
    t_key_fail();
    t_data_stall();
    t_full_discard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule